// File: doc/BRIEF.md
# Multimode Timer Channel with Capture

This block is one timer channel behind a simple 32-bit register bus. A single counter serves four modes. In compare mode it counts to a limit and then acts on an output pin. In two-phase PWM mode it holds the pin at one level for a first count and at the other level for a second count. In pulse capture mode it measures the width of one pulse on a capture input. In duty capture mode it measures both the full period and the active part of a repeating capture signal. In compare and PWM modes the count advances on every system clock or on a chosen edge of an external clock input.

Each finished interval raises an event. An event sets a pending status bit, and the status drives the interrupt line through an enable and a mask. If another event arrives while the status is still pending, a sticky overrun bit records it. Software programs the channel through the configuration word and reads the results back from status registers.

Top module: `mmt_timer`

## Requirements
- R1: After synchronous reset every readable register reads 0, and `tmr_out` and `irq` are 0.
- R2: The register offsets are CFG 0x00, LIMIT 0x04, COUNT 0x08, PERIOD_CAP 0x0C, HIGH_CAP 0x10, PHASE 0x14, PIN 0x18, IRQ_CTRL 0x1C, IRQ_RAW 0x20, IRQ_MASKED 0x24 and IRQ_OVR 0x28. CFG and LIMIT read back what was written. CFG bits are: 0 run, 2:1 mode (0 compare, 1 PWM, 2 pulse capture, 3 duty capture), 3 external clock, 5:4 pin action (0 none, 1 toggle, 2 high, 3 low), 6 falling edge, 7 single shot, 8 idle level.
- R3: In compare mode with limit T, COUNT reads k after k ticks. The T-th tick raises an event and returns COUNT to 0, and counting continues.
- R4: On a compare-mode event the pin follows the action field: unchanged, toggled, driven high or driven low.
- R5: With single shot set, the event clears the run bit in the next cycle and the counter then stays at 0.
- R6: With the external clock selected, COUNT advances exactly once per rising edge of `ext_clk_in`, or once per falling edge when bit 6 is set. With no edges, COUNT does not change.
- R7: In PWM mode LIMIT[15:0] is the phase-0 length and LIMIT[31:16] is the phase-1 length. The pin is at the idle level in phase 0 and at the inverse level in phase 1. PHASE reads the current phase. Each completed phase 1 raises an event.
- R8: In pulse capture mode HIGH_CAP receives the width, in system clocks, from an active edge of `cap_in` to the opposite edge. The active edge is rising, or falling when bit 6 is set. Each completed measurement raises an event.
- R9: In duty capture mode PERIOD_CAP receives the clocks between two active edges and HIGH_CAP receives the clocks from an active edge to the following opposite edge. Each period raises an event.
- R10: `irq` = IRQ_RAW AND IRQ_CTRL bit 0 (enable) AND NOT IRQ_CTRL bit 1 (mask). IRQ_MASKED reads the same value.
- R11: An event that arrives while IRQ_RAW is 1 sets IRQ_OVR. Writing 1 to bit 0 of IRQ_RAW clears both bits.
- R12: A write to CFG loads the pin with the idle bit. While running in PWM mode the pin reads the idle level during phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ext_clk_in | input | 1 | Asynchronous external count clock |
| cap_in | input | 1 | Asynchronous capture input |
| tmr_out | output | 1 | Timer output pin |
| irq | output | 1 | Interrupt request |

## Verification
Assertions check four things on every cycle. Each synchronised edge strobe lasts exactly one cycle. The PWM phase only changes on a tick. The capture registers only change on capture edges. A single-shot event always clears the run bit, and overrun only rises while a status is pending. The bench scenarios show the values that depend on intervals: compare period and restart, the pin actions, the PWM waveform, edge counting on the external clock, and the captured widths. They also show the enable and mask combination of the interrupt line and the clear by write.

// File: rtl/mmt_pkg.sv
// Shared types and register offsets for the multimode timer channel.
// Assumes a byte-addressed register bus with 32-bit registers.
package mmt_pkg;
    typedef enum logic [1:0] {
        MODE_COUNT = 2'd0,
        MODE_PWM   = 2'd1,
        MODE_PULSE = 2'd2,
        MODE_DUTY  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_LOW    = 2'd3
    } act_e;

    // Configuration word, MSB first: idle, single, fall_edge, act, ext_clk, mode, run
    typedef struct packed {
        logic  idle;
        logic  single;
        logic  fall_edge;
        act_e  act;
        logic  ext_clk;
        mode_e mode;
        logic  run;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    localparam int OFS_CFG     = 'h00;
    localparam int OFS_LIMIT   = 'h04;
    localparam int OFS_COUNT   = 'h08;
    localparam int OFS_PERIOD  = 'h0C;
    localparam int OFS_HIGH    = 'h10;
    localparam int OFS_PHASE   = 'h14;
    localparam int OFS_PIN     = 'h18;
    localparam int OFS_IRQCTL  = 'h1C;
    localparam int OFS_IRQRAW  = 'h20;
    localparam int OFS_IRQMSK  = 'h24;
    localparam int OFS_IRQOVR  = 'h28;
endpackage

// File: rtl/mmt_edge_sync.sv
// Brings an asynchronous input into the clock domain through a flop chain
// and produces one-cycle strobes for its rising and falling edges.
// Assumes the input holds each level for longer than one clock period.
module mmt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the raw input through the synchroniser and keep the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Edge strobes are taken on the synchronised level only.
    always_comb begin
        rise = sync_q[STAGES-1] & ~prev_q;
        fall = ~sync_q[STAGES-1] & prev_q;
    end

    // R6
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    // R6
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/mmt_core.sv
// Counter shared by all four modes: compare, two-phase PWM, pulse capture
// and duty capture. Emits a one-cycle event per finished interval and a
// stop request in single-shot mode. Assumes edge strobes last one cycle.
module mmt_core import mmt_pkg::*; #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  mode_e        mode,
    input  logic         ext_clk,
    input  logic         fall_edge,
    input  logic         single,
    input  logic [W-1:0] limit,
    input  logic         ext_rise,
    input  logic         ext_fall,
    input  logic         cap_rise,
    input  logic         cap_fall,
    output logic [W-1:0] cnt,
    output logic [W-1:0] period_cap,
    output logic [W-1:0] high_cap,
    output logic         phase,
    output logic         evt,
    output logic         stop_req
);
    localparam int HALF = W / 2;
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q, cnt_d, cyc_q, cyc_d, pw_q, pw_d, cnt_inc;
    logic [W-1:0] len0, len1;
    logic         phase_q, phase_d, armed_q, armed_d;
    logic         tick, cap_start, cap_end;

    // Select the count strobe and the capture edge roles.
    always_comb begin
        tick      = ext_clk ? (fall_edge ? ext_fall : ext_rise) : 1'b1;
        cap_start = fall_edge ? cap_fall : cap_rise;
        cap_end   = fall_edge ? cap_rise : cap_fall;
        cnt_inc   = cnt_q + ONE;
        len0      = {{(W-HALF){1'b0}}, limit[HALF-1:0]};
        len1      = {{HALF{1'b0}}, limit[W-1:HALF]};
    end

    // Next-state logic for the shared counter in each mode.
    always_comb begin
        cnt_d    = cnt_q;
        phase_d  = phase_q;
        armed_d  = armed_q;
        cyc_d    = cyc_q;
        pw_d     = pw_q;
        evt      = 1'b0;
        stop_req = 1'b0;
        if (!en) begin
            cnt_d   = '0;
            phase_d = 1'b0;
            armed_d = 1'b0;
        end else begin
            case (mode)
                MODE_COUNT: if (tick) begin
                    if (cnt_inc == limit) begin
                        evt      = 1'b1;
                        cnt_d    = '0;
                        stop_req = single;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
                MODE_PWM: if (tick) begin
                    if (!phase_q && cnt_inc >= len0) begin
                        phase_d = 1'b1;
                        cnt_d   = '0;
                    end else if (phase_q && cnt_inc >= len1) begin
                        phase_d = 1'b0;
                        cnt_d   = '0;
                        evt     = 1'b1;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
                MODE_PULSE: begin
                    if (cap_start) begin
                        armed_d = 1'b1;
                        cnt_d   = ONE;
                    end else if (armed_q) begin
                        if (cap_end) begin
                            pw_d     = cnt_q;
                            evt      = 1'b1;
                            armed_d  = 1'b0;
                            stop_req = single;
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end
                end
                default: begin
                    if (cap_start) begin
                        if (armed_q) begin
                            cyc_d    = cnt_q;
                            evt      = 1'b1;
                            stop_req = single;
                        end
                        armed_d = 1'b1;
                        cnt_d   = ONE;
                    end else if (armed_q) begin
                        if (cap_end) pw_d = cnt_q;
                        cnt_d = cnt_inc;
                    end
                end
            endcase
        end
    end

    // Register the counter, phase and capture results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
            armed_q <= 1'b0;
            cyc_q   <= '0;
            pw_q    <= '0;
        end else begin
            cnt_q   <= cnt_d;
            phase_q <= phase_d;
            armed_q <= armed_d;
            cyc_q   <= cyc_d;
            pw_q    <= pw_d;
        end
    end

    assign cnt        = cnt_q;
    assign period_cap = cyc_q;
    assign high_cap   = pw_q;
    assign phase      = phase_q;

    // R7
    pwm_phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == MODE_PWM && !tick) |=> ($stable(phase_q) || !en));
    // R8
    high_cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_rise || cap_fall) |=> $stable(pw_q));
    // R9
    period_cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_rise || cap_fall) |=> $stable(cyc_q));
endmodule

// File: rtl/mmt_irq.sv
// Pending status, sticky overrun and masked interrupt output.
// Assumes evt is a one-cycle pulse; a new event outranks a clear in the same cycle.
module mmt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    input  logic ien,
    input  logic imask,
    output logic raw,
    output logic ovr,
    output logic irq
);
    logic raw_q, ovr_q;

    // Track the pending status and the overrun of a still-pending status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            raw_q <= evt | (raw_q & ~clr);
            ovr_q <= ~clr & (ovr_q | (evt & raw_q));
        end
    end

    assign raw = raw_q;
    assign ovr = ovr_q;
    assign irq = raw_q & ien & ~imask;

    // R11
    ovr_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(raw_q));
    // R11
    raw_fall_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(raw_q) |-> $past(clr));
endmodule

// File: rtl/mmt_timer.sv
// Top of the timer channel: register file, read mux, pin control and the
// wiring of synchronisers, counter core and interrupt logic.
// Assumes single-cycle writes and a combinational read path.
module mmt_timer import mmt_pkg::*; #(
    parameter int W           = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              ext_clk_in,
    input  logic              cap_in,
    output logic              tmr_out,
    output logic              irq
);
    cfg_t         cfg_q, cfg_wval;
    logic [W-1:0] limit_q, cnt, period_cap, high_cap;
    logic [1:0]   ictl_q;
    logic         pin_q, phase, evt, stop_req, raw, ovr;
    logic         ext_rise, ext_fall, cap_rise, cap_fall;
    logic         wr_cfg, wr_limit, wr_ictl, wr_raw;

    // Decode writes per register.
    always_comb begin
        cfg_wval = cfg_t'(bus_wdata[CFG_W-1:0]);
        wr_cfg   = bus_wr && (bus_addr == ADDR_W'(OFS_CFG));
        wr_limit = bus_wr && (bus_addr == ADDR_W'(OFS_LIMIT));
        wr_ictl  = bus_wr && (bus_addr == ADDR_W'(OFS_IRQCTL));
        wr_raw   = bus_wr && (bus_addr == ADDR_W'(OFS_IRQRAW)) && bus_wdata[0];
    end

    // Hold configuration registers; a single-shot stop outranks a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            limit_q <= '0;
            ictl_q  <= '0;
        end else begin
            if (wr_cfg)   cfg_q   <= cfg_wval;
            if (wr_limit) limit_q <= bus_wdata;
            if (wr_ictl)  ictl_q  <= bus_wdata[1:0];
            if (stop_req) cfg_q.run <= 1'b0;
        end
    end

    // Pin level: loaded from idle on a config write, changed by compare events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else if (wr_cfg) begin
            pin_q <= cfg_wval.idle;
        end else if (evt && cfg_q.mode == MODE_COUNT) begin
            case (cfg_q.act)
                ACT_TOGGLE: pin_q <= ~pin_q;
                ACT_HIGH:   pin_q <= 1'b1;
                ACT_LOW:    pin_q <= 1'b0;
                default:    pin_q <= pin_q;
            endcase
        end
    end

    assign tmr_out = (cfg_q.run && cfg_q.mode == MODE_PWM) ? (cfg_q.idle ^ phase) : pin_q;

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_CFG):    bus_rdata = W'(cfg_q);
            ADDR_W'(OFS_LIMIT):  bus_rdata = limit_q;
            ADDR_W'(OFS_COUNT):  bus_rdata = cnt;
            ADDR_W'(OFS_PERIOD): bus_rdata = period_cap;
            ADDR_W'(OFS_HIGH):   bus_rdata = high_cap;
            ADDR_W'(OFS_PHASE):  bus_rdata = W'(phase);
            ADDR_W'(OFS_PIN):    bus_rdata = W'(tmr_out);
            ADDR_W'(OFS_IRQCTL): bus_rdata = W'(ictl_q);
            ADDR_W'(OFS_IRQRAW): bus_rdata = W'(raw);
            ADDR_W'(OFS_IRQMSK): bus_rdata = W'(irq);
            ADDR_W'(OFS_IRQOVR): bus_rdata = W'(ovr);
            default:             bus_rdata = '0;
        endcase
    end

    mmt_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_clk_in), .rise(ext_rise), .fall(ext_fall)
    );

    mmt_edge_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
        .clk(clk), .rst_n(rst_n), .din(cap_in), .rise(cap_rise), .fall(cap_fall)
    );

    mmt_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(cfg_q.run), .mode(cfg_q.mode),
        .ext_clk(cfg_q.ext_clk), .fall_edge(cfg_q.fall_edge), .single(cfg_q.single),
        .limit(limit_q), .ext_rise(ext_rise), .ext_fall(ext_fall),
        .cap_rise(cap_rise), .cap_fall(cap_fall), .cnt(cnt),
        .period_cap(period_cap), .high_cap(high_cap), .phase(phase),
        .evt(evt), .stop_req(stop_req)
    );

    mmt_irq u_irq (
        .clk(clk), .rst_n(rst_n), .evt(evt), .clr(wr_raw),
        .ien(ictl_q[0]), .imask(ictl_q[1]), .raw(raw), .ovr(ovr), .irq(irq)
    );

    // R5
    single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !cfg_q.run);
    // R10
    irq_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> raw);
endmodule

// File: tb/mmt_timer_tb.sv
`timescale 1ns/10ps
module mmt_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_clk_in = 1'b0;
    logic        cap_in = 1'b0;
    logic        tmr_out, irq;

    typedef struct {
        string       req;
        logic [31:0] exp;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] obs_val;
    event        obs_ev;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    mmt_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk_in(ext_clk_in),
        .cap_in(cap_in), .tmr_out(tmr_out), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // Monitor: pop the expected item and compare with the observed value.
    always begin
        exp_t e;
        @(obs_ev);
        n_chk++;
        if (sb_q.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard: got %h expected none", obs_val);
        end else begin
            e = sb_q.pop_front();
            if (obs_val !== e.exp) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", e.req, obs_val, e.exp);
            end
        end
    end

    task automatic expect_val(input string req, input logic [31:0] act, input logic [31:0] exp);
        sb_q.push_back('{req, exp});
        obs_val = act;
        -> obs_ev;
        #0.1;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        #0.1;
        expect_val(req, bus_rdata, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ext_pulse(input int h, input int l);
        ext_clk_in = 1'b1; tick(h);
        ext_clk_in = 1'b0; tick(l);
    endtask

    task automatic cap_pulse(input int h, input int l);
        cap_in = 1'b1; tick(h);
        cap_in = 1'b0; tick(l);
    endtask

    localparam logic [7:0] A_CFG = 8'h00, A_LIM = 8'h04, A_CNT = 8'h08, A_PER = 8'h0C,
                           A_HI = 8'h10, A_PH = 8'h14, A_PIN = 8'h18, A_ICTL = 8'h1C,
                           A_RAW = 8'h20, A_MSK = 8'h24, A_OVR = 8'h28;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(A_CFG, 0, "R1 cfg");
        rd_chk(A_CNT, 0, "R1 count");
        rd_chk(A_RAW, 0, "R1 raw");
        expect_val("R1 pin", 32'(tmr_out), 0);
        expect_val("R1 irq", 32'(irq), 0);

        // R2 read back, R12 idle load
        wr(A_LIM, 32'hDEADBEEF);
        rd_chk(A_LIM, 32'hDEADBEEF, "R2 limit");
        wr(A_CFG, 32'h1F6);
        rd_chk(A_CFG, 32'h1F6, "R2 cfg");
        expect_val("R12 idle load", 32'(tmr_out), 1);
        wr(A_CFG, 0);

        // R3 and R4 compare with toggle, limit 5
        wr(A_LIM, 5);
        wr(A_CFG, 32'h11);
        tick(3);
        rd_chk(A_CNT, 3, "R3 count");
        rd_chk(A_RAW, 0, "R3 no event yet");
        tick(2);
        rd_chk(A_RAW, 1, "R3 event");
        rd_chk(A_CNT, 0, "R3 restart");
        expect_val("R4 toggle", 32'(tmr_out), 1);
        tick(2);
        rd_chk(A_CNT, 2, "R3 loop");
        tick(3);
        expect_val("R4 toggle back", 32'(tmr_out), 0);
        rd_chk(A_OVR, 1, "R11 overrun");
        wr(A_CFG, 0);

        // R10 enable and mask
        expect_val("R10 irq disabled", 32'(irq), 0);
        wr(A_ICTL, 1);
        expect_val("R10 irq enabled", 32'(irq), 1);
        rd_chk(A_MSK, 1, "R10 masked status");
        wr(A_ICTL, 3);
        expect_val("R10 irq masked", 32'(irq), 0);
        rd_chk(A_MSK, 0, "R10 masked status off");
        rd_chk(A_RAW, 1, "R10 raw stays");
        // R11 clear
        wr(A_RAW, 1);
        rd_chk(A_RAW, 0, "R11 raw cleared");
        rd_chk(A_OVR, 0, "R11 overrun cleared");
        wr(A_ICTL, 1);

        // R5 single shot with drive high, limit 3
        wr(A_LIM, 3);
        wr(A_CFG, 32'hA1);
        tick(2);
        expect_val("R4 before high", 32'(tmr_out), 0);
        tick(1);
        expect_val("R4 drive high", 32'(tmr_out), 1);
        rd_chk(A_CFG, 32'hA0, "R5 run cleared");
        expect_val("R10 irq asserted", 32'(irq), 1);
        tick(4);
        rd_chk(A_CNT, 0, "R5 stopped");
        rd_chk(A_OVR, 0, "R5 no second event");

        // R4 drive low, idle 1, limit 2
        wr(A_LIM, 2);
        wr(A_CFG, 32'h1B1);
        expect_val("R12 idle high", 32'(tmr_out), 1);
        tick(2);
        expect_val("R4 drive low", 32'(tmr_out), 0);
        // R4 no action
        wr(A_CFG, 32'h101);
        tick(4);
        expect_val("R4 none", 32'(tmr_out), 1);
        wr(A_CFG, 0);

        // R6 external clock, rising then falling
        wr(A_RAW, 1);
        wr(A_LIM, 100);
        wr(A_CFG, 32'h09);
        tick(5);
        rd_chk(A_CNT, 0, "R6 no edges");
        for (int i = 0; i < 3; i++) ext_pulse(4, 4);
        tick(4);
        rd_chk(A_CNT, 3, "R6 rising count");
        wr(A_CFG, 0);
        wr(A_CFG, 32'h49);
        for (int i = 0; i < 2; i++) ext_pulse(4, 4);
        tick(4);
        rd_chk(A_CNT, 2, "R6 falling count");
        wr(A_CFG, 0);

        // R7 PWM, phase0 = 3, phase1 = 2, idle 0
        wr(A_RAW, 1);
        wr(A_LIM, {16'd2, 16'd3});
        wr(A_CFG, 32'h03);
        for (int k = 0; k < 10; k++) begin
            expect_val("R7 pwm pin", 32'(tmr_out), ((k % 5) >= 3) ? 1 : 0);
            rd_chk(A_PH, ((k % 5) >= 3) ? 1 : 0, "R7 phase");
            if (k == 4) rd_chk(A_RAW, 0, "R7 no event mid cycle");
            if (k == 5) rd_chk(A_RAW, 1, "R7 cycle event");
            tick(1);
        end
        wr(A_CFG, 0);
        wr(A_CFG, 32'h103);
        expect_val("R12 pwm idle high", 32'(tmr_out), 1);
        tick(3);
        expect_val("R7 pwm inverted phase", 32'(tmr_out), 0);
        wr(A_CFG, 0);

        // R8 pulse capture, rising active then falling active
        wr(A_RAW, 1);
        wr(A_CFG, 32'h05);
        cap_pulse(7, 6);
        rd_chk(A_HI, 7, "R8 high width");
        rd_chk(A_RAW, 1, "R8 event");
        wr(A_CFG, 0);
        wr(A_RAW, 1);
        wr(A_CFG, 32'h45);
        cap_in = 1'b1; tick(6);
        cap_in = 1'b0; tick(5);
        cap_in = 1'b1; tick(6);
        rd_chk(A_HI, 5, "R8 low width");
        wr(A_CFG, 0);
        cap_in = 1'b0; tick(4);

        // R9 duty capture, high 4 low 6
        wr(A_RAW, 1);
        wr(A_CFG, 32'h07);
        cap_pulse(4, 6);
        cap_pulse(4, 6);
        cap_in = 1'b1; tick(6);
        rd_chk(A_PER, 10, "R9 period");
        rd_chk(A_HI, 4, "R9 high part");
        rd_chk(A_RAW, 1, "R9 event");
        rd_chk(A_OVR, 1, "R11 overrun in capture");
        wr(A_CFG, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule